// File: doc/BRIEF.md
# Cache Line-Fill Qualifier with Flush Control

This block lives in the bus interface unit of a write-through cached processor. It watches one outstanding read cycle at a time. It decides whether that cycle grows into a multi-transfer line fill, and whether the filled line is finally written into the on-chip cache. Both decisions come from an active-low cache-enable pin. The block judges that pin by the level it had one clock before a ready strobe, not by its level at the strobe itself. There are two ready strobes: a single-transfer one and a burst one.

The cache-enable sample taken before the first transfer starts the fill. A second sample, taken before the final transfer, decides whether the line is kept. A fill can therefore run to completion and still be thrown away. The block also turns an active-low flush pin into a one-cycle invalidate-all pulse for the tag store, without starting any bus activity. Finally, it latches a three-state test-mode flag when flush is held low on the last clock of reset.

Top module: `lf_line_fill_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, fill_mode_o, commit_o, xfer_cnt_o and flush_inv_o are 0; test_mode_o is 0 when flush_n_i was high on the last reset clock.
- R2: A cycle begun with cacheable_i=1 becomes a line fill when ken_n_i was 0 on the clock edge before the first edge with rdy_n_i=0 or brdy_n_i=0. After that first-transfer edge, fill_mode_o=1 and xfer_cnt_o=1.
- R3: When cacheable_i was 0 at the start, or ken_n_i was 1 one clock before the first ready edge, the cycle ends after that single transfer. In that case fill_mode_o stays 0, xfer_cnt_o stays 0 and commit_o is never raised.
- R4: Only the cache-enable level one clock before a ready edge counts. Its level at the ready edge itself, and its level in earlier wait cycles, have no effect.
- R5: During a fill, each ready edge advances xfer_cnt_o by one. After the fourth transfer, xfer_cnt_o returns to 0 and fill_mode_o drops to 0.
- R6: commit_o is high for exactly the one cycle after the fourth transfer, and only when ken_n_i was 0 one clock before that final ready edge.
- R7: A flush_n_i low level seen on one clock edge, after it was high on the previous edge, gives flush_inv_o=1 for exactly the following cycle. Holding flush low longer gives no further pulse.
- R8: Flush does not disturb a fill in progress: fill_mode_o, xfer_cnt_o and commit_o follow R2 to R6 unchanged.
- R9: flush_n_i=0 on the last clock edge with reset high sets test_mode_o=1 from the first cycle after reset until the next reset, and raises no flush pulse. A low flush on earlier reset edges only does not set it.
- R10: Ready strobes arriving while no cycle is outstanding are ignored (fill_mode_o and xfer_cnt_o stay 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start_i | input | 1 | One-cycle pulse starting a read cycle |
| cacheable_i | input | 1 | Core marks the starting cycle as cacheable (taken with cyc_start_i) |
| ken_n_i | input | 1 | Cache enable, active low |
| rdy_n_i | input | 1 | Single-transfer ready, active low |
| brdy_n_i | input | 1 | Burst ready, active low |
| flush_n_i | input | 1 | Cache flush request, active low |
| fill_mode_o | output | 1 | Current cycle is a line fill |
| commit_o | output | 1 | One-cycle strobe: write the filled line into the cache |
| xfer_cnt_o | output | CNT_W (2) | Transfers completed in the current fill |
| flush_inv_o | output | 1 | One-cycle invalidate-all pulse |
| test_mode_o | output | 1 | Three-state test mode entered |

## Verification
Every output is registered. fill_mode_o, xfer_cnt_o and commit_o change in the cycle after the ready edge that causes them. flush_inv_o follows one cycle after the first low flush sample. test_mode_o follows one cycle after reset falls. The bench drives inputs on falling edges and reads results on the next falling edge, half a cycle after the rising edge due to update them. It sets ken_n_i to the opposite level both in the wait cycles and at the ready edge itself. This way only a sample taken exactly one clock before the ready edge can give the expected result. The sweep covers every mix of cacheability, first-sample level, last-sample level, ready strobe type and wait-state count.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } lf_state_e;

    typedef struct packed {
        logic arm;       // flush sampled low on the latest reset edge
        logic prev_low;  // flush sampled low on the previous edge
        logic inv;       // invalidate-all pulse
        logic test;      // three-state test mode flag
    } flush_state_t;

endpackage

// File: rtl/lf_strobe_sampler.sv
module lf_strobe_sampler (
    input  logic clk,
    input  logic rst,
    input  logic ken_n_i,
    input  logic rdy_n_i,
    input  logic brdy_n_i,
    output logic ken_prev_o,
    output logic xfer_o
);

    logic ken_d, ken_q;

    always_comb begin
        ken_d = ~ken_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) ken_q <= 1'b0;
        else     ken_q <= ken_d;
    end

    // cache-enable level as seen one clock before the current edge
    assign ken_prev_o = ken_q;
    // either ready strobe completes one transfer
    assign xfer_o     = ~rdy_n_i | ~brdy_n_i;

endmodule

// File: rtl/lf_fill_fsm.sv
module lf_fill_fsm #(
    parameter  int BEATS = 4,
    localparam int CNT_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start_i,
    input  logic             cacheable_i,
    input  logic             xfer_i,
    input  logic             ken_prev_i,
    output logic             fill_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             commit_o
);
    import lf_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    typedef struct packed {
        lf_state_e        st;
        logic             cacheable;
        logic             fill;
        logic [CNT_W-1:0] cnt;
        logic             commit;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cyc_start_i) begin
                    d.st        = ST_BUSY;
                    d.cacheable = cacheable_i;
                    d.fill      = 1'b0;
                    d.cnt       = '0;
                end
            end
            ST_BUSY: begin
                if (xfer_i) begin
                    if (!q.fill) begin
                        if (q.cacheable && ken_prev_i) begin
                            d.fill = 1'b1;
                            d.cnt  = CNT_W'(1);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else if (q.cnt == LAST) begin
                        d.st     = ST_IDLE;
                        d.fill   = 1'b0;
                        d.cnt    = '0;
                        d.commit = ken_prev_i;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: ST_IDLE, cacheable: 1'b0, fill: 1'b0, cnt: '0, commit: 1'b0};
        else     q <= d;
    end

    assign fill_o   = q.fill;
    assign cnt_o    = q.cnt;
    assign commit_o = q.commit;

    a_r5_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
        !q.fill |-> (q.cnt == '0));

    a_r6_commit_ends_fill: assert property (@(posedge clk) disable iff (rst)
        q.commit |-> ($past(q.fill) && !q.fill));

    a_r2_fill_needs_cacheable: assert property (@(posedge clk) disable iff (rst)
        $rose(q.fill) |-> q.cacheable);

    a_r3_single_no_commit: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_BUSY && !q.fill && xfer_i && !(q.cacheable && ken_prev_i))
        |=> (!q.commit && !q.fill));

    a_r10_idle_ignores_ready: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && !cyc_start_i) |=> (!q.fill && q.cnt == '0));

endmodule

// File: rtl/lf_flush_ctrl.sv
module lf_flush_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic flush_n_i,
    output logic flush_inv_o,
    output logic test_mode_o
);
    import lf_pkg::*;

    flush_state_t q, d;

    always_comb begin
        d          = q;
        d.arm      = 1'b0;
        d.test     = q.test | q.arm;
        d.prev_low = ~flush_n_i;
        d.inv      = ~flush_n_i & ~q.prev_low;
    end

    // while reset is held, keep tracking the flush pin so the last
    // reset edge decides test mode
    always_ff @(posedge clk) begin
        if (rst) q <= '{arm: ~flush_n_i, prev_low: ~flush_n_i, inv: 1'b0, test: 1'b0};
        else     q <= d;
    end

    assign flush_inv_o = q.inv;
    assign test_mode_o = q.test;

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        q.inv |=> !q.inv);

    a_r9_test_sticky: assert property (@(posedge clk) disable iff (rst)
        q.test |=> q.test);

endmodule

// File: rtl/lf_line_fill_ctrl.sv
module lf_line_fill_ctrl #(
    parameter  int BEATS = 4,
    localparam int CNT_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start_i,
    input  logic             cacheable_i,
    input  logic             ken_n_i,
    input  logic             rdy_n_i,
    input  logic             brdy_n_i,
    input  logic             flush_n_i,
    output logic             fill_mode_o,
    output logic             commit_o,
    output logic [CNT_W-1:0] xfer_cnt_o,
    output logic             flush_inv_o,
    output logic             test_mode_o
);

    logic ken_prev;
    logic xfer;

    lf_strobe_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .ken_n_i   (ken_n_i),
        .rdy_n_i   (rdy_n_i),
        .brdy_n_i  (brdy_n_i),
        .ken_prev_o(ken_prev),
        .xfer_o    (xfer)
    );

    lf_fill_fsm #(.BEATS(BEATS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cyc_start_i(cyc_start_i),
        .cacheable_i(cacheable_i),
        .xfer_i     (xfer),
        .ken_prev_i (ken_prev),
        .fill_o     (fill_mode_o),
        .cnt_o      (xfer_cnt_o),
        .commit_o   (commit_o)
    );

    lf_flush_ctrl u_flush (
        .clk        (clk),
        .rst        (rst),
        .flush_n_i  (flush_n_i),
        .flush_inv_o(flush_inv_o),
        .test_mode_o(test_mode_o)
    );

    a_r8_flush_keeps_fill: assert property (@(posedge clk) disable iff (rst)
        (flush_inv_o && fill_mode_o && xfer_cnt_o != '0) |-> $stable(fill_mode_o));

endmodule

// File: tb/lf_line_fill_ctrl_bench.sv
module lf_line_fill_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst, cyc_start, cacheable, ken_n, rdy_n, brdy_n, flush_n;
    logic       fill_mode, commit, flush_inv, test_mode;
    logic [1:0] xfer_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lf_line_fill_ctrl u_lf_line_fill_ctrl (
        .clk(clk), .rst(rst), .cyc_start_i(cyc_start), .cacheable_i(cacheable),
        .ken_n_i(ken_n), .rdy_n_i(rdy_n), .brdy_n_i(brdy_n), .flush_n_i(flush_n),
        .fill_mode_o(fill_mode), .commit_o(commit), .xfer_cnt_o(xfer_cnt),
        .flush_inv_o(flush_inv), .test_mode_o(test_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    // one read cycle; kf/kl = cache-enable active before first/last ready
    task automatic run_line(input bit cach, input bit kf, input bit kl,
                            input bit useb, input int w);
        bit fill_exp;
        int nb;
        bit kv;
        fill_exp = cach & kf;
        nb = fill_exp ? 4 : 1;
        @(negedge clk);
        cyc_start = 1'b1; cacheable = cach; ken_n = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0; cacheable = 1'b0;
        for (int t = 0; t < nb; t++) begin
            kv = (t == 0) ? kf : ((t == nb - 1) ? kl : 1'b0);
            ken_n = kv;  // wrong level during waits (R4)
            repeat (w) @(negedge clk);
            ken_n = ~kv;
            if (t == 1) flush_n = 1'b0;
            @(negedge clk);
            ken_n = kv;  // wrong level at the ready edge (R4)
            if (useb) brdy_n = 1'b0; else rdy_n = 1'b0;
            flush_n = 1'b1;
            if (t == 1) chk("R7 flush pulse during fill", flush_inv, 1);
            @(negedge clk);
            rdy_n = 1'b1; brdy_n = 1'b1;
            if (t == 0) begin
                chk("R2/R3/R4 fill decision", fill_mode, fill_exp);
                chk("R2/R3 count after first", xfer_cnt, fill_exp ? 1 : 0);
                if (!fill_exp) chk("R3 single no commit", commit, 0);
            end else if (t < nb - 1) begin
                chk("R5 count mid fill", xfer_cnt, t + 1);
                chk("R8 fill kept across flush", fill_mode, 1);
                if (t == 1) chk("R7 single flush pulse", flush_inv, 0);
            end else begin
                chk("R5 count wraps", xfer_cnt, 0);
                chk("R5 fill ends", fill_mode, 0);
                chk("R6 commit decision", commit, kl);
            end
        end
        ken_n = 1'b1;
        @(negedge clk);
        chk("R6 commit one cycle", commit, 0);
    endtask

    initial begin
        rst = 1'b1; cyc_start = 1'b0; cacheable = 1'b0; ken_n = 1'b1;
        rdy_n = 1'b1; brdy_n = 1'b1; flush_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 fill in reset", fill_mode, 0);
        chk("R1 flush in reset", flush_inv, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fill", fill_mode, 0);
        chk("R1 count", xfer_cnt, 0);
        chk("R1 commit", commit, 0);
        chk("R1 flush", flush_inv, 0);
        chk("R1 test mode", test_mode, 0);

        rdy_n = 1'b0; ken_n = 1'b0;
        @(negedge clk);
        rdy_n = 1'b1; brdy_n = 1'b0;
        chk("R10 idle ready fill", fill_mode, 0);
        @(negedge clk);
        brdy_n = 1'b1; ken_n = 1'b1;
        chk("R10 idle ready count", xfer_cnt, 0);

        for (int s = 0; s < 32; s++)
            run_line(s[4], s[3], s[2], s[1], s[0] ? 2 : 0);

        // held flush gives a single pulse
        flush_n = 1'b0;
        @(negedge clk); chk("R7 held flush first", flush_inv, 1);
        @(negedge clk); chk("R7 held flush second", flush_inv, 0);
        @(negedge clk); chk("R7 held flush third", flush_inv, 0);
        flush_n = 1'b1;
        @(negedge clk);

        // flush low on last reset edge: test mode
        rst = 1'b1; flush_n = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 test mode entered", test_mode, 1);
        chk("R9 no flush pulse on entry", flush_inv, 0);
        flush_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 test mode sticky", test_mode, 1);
        run_line(1'b1, 1'b1, 1'b1, 1'b0, 1);
        chk("R9 test mode after fill", test_mode, 1);

        // flush low earlier in reset only: no test mode
        rst = 1'b1; flush_n = 1'b0;
        @(negedge clk);
        flush_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 no test mode", test_mode, 0);
        chk("R1 flush after reset", flush_inv, 0);

        summary();
        $finish;
    end

endmodule